// File: doc/BRIEF.md
# Return Address Guard with Shadow Stack

This block protects subroutine returns. On each call event it computes the return address, which is the next 32-bit instruction slot, or the start of the next 256-bit block when the call sits in the last used slot of its block. It then forms the 64-bit word that the call saves in its return register.

When guidance is on, the saved word carries a 12-bit keyed digest in its upper bits above a 52-bit address. The same word is also pushed onto a hidden last-in-first-out stack. The key is a random seed that is latched while reset is held.

Each jump event comes with a target class from an external prefix decoder. A jump whose target is marked as a return pops the hidden stack and compares the full jump address against the popped word. A mismatch, or a pop from an empty stack, raises a violation pulse. Calls whose target is marked as a base-register setup push nothing.

Top module: `callguard`

## Requirements
- R1: For a call not in the last used slot, the return address is `(pc & ~3) + 4`. The saved word appears on `ret_word_o` in the cycle after the call and holds until the next call.
- R2: For a call flagged as the last used slot (`call_last_i`=1), the return address is `(pc & ~31) + 32`, with the addition taken modulo 2^64.
- R3: With `guard_en_i`=0, `ret_word_o` is the plain 64-bit return address. The stack is neither pushed nor popped, and no violation is raised.
- R4: With `guard_en_i`=1, `ret_word_o` is `{digest[11:0], ret_addr[51:0]}`.
- R5: The digest is computed in three steps. First, `m = (({12'b0, ret_addr[51:0]}) ^ key) * 64'h9E3779B97F4A7C15 mod 2^64`. Second, `r` is `m` rotated left by 23. Third, the digest is the XOR of the 12-bit chunks of `r` at bits 0, 12, 24, 36 and 48, and `r[63:60]` zero-extended.
- R6: The key is the value of `seed_i` sampled while `rst_n` is low. Later changes of `seed_i` do not affect the digest.
- R7: Target class encoding is 00 plain, 01 return, 10 setup, 11 treated as plain. An enabled call pushes its saved word unless its class is setup.
- R8: An enabled jump with class return pops the newest entry. If the jump address differs from that entry in any of its 64 bits, `violation_o` is high for the one cycle after the jump. Entries come back in reverse order of pushing.
- R9: An enabled return-class jump on an empty stack raises the same one-cycle violation.
- R10: A jump with a class other than return neither pops nor raises a violation.
- R11: The stack holds 16 entries. A push while full discards the oldest entry, so after 17 pushes, 16 pops match the 16 newest words and the 17th pop finds the stack empty.
- R12: When a call and a jump occur in the same cycle, the call is processed and the jump is ignored.
- R13: After reset, `ret_word_o` is 0, `violation_o` is 0 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the key is latched while low |
| guard_en_i | input | 1 | Control-flow guidance enable |
| seed_i | input | 64 | Power-up random seed |
| call_i | input | 1 | Call event this cycle |
| call_pc_i | input | 64 | Address of the calling instruction |
| call_last_i | input | 1 | Call sits in the last used instruction slot of its block |
| jump_i | input | 1 | Jump event this cycle |
| jump_addr_i | input | 64 | Effective address of the jump |
| tgt_cls_i | input | 2 | Class of the event's target (00 plain, 01 return, 10 setup) |
| ret_word_o | output | 64 | Word to be saved in the return register |
| violation_o | output | 1 | One-cycle pulse on a failed return check |

## Verification
The bench sweeps every slot position, both settings of the last-slot flag and several base addresses, including halfword-aligned ones and one that wraps at the top of the address space. A design that forgot the alignment mask or the block-start rule would return wrong addresses.

It fills the stack past its depth and then drains it. A design that overwrote the newest entry, or saturated without discarding the oldest, would either flag a correct return or miss the final empty pop.

Setup-class calls, plain-class jumps, disabled guidance and a call coinciding with a jump are each followed by a correct return. A design that pushed or popped when it should not have would raise a violation there or miss one later. The digest is checked against a key changed after reset, so a design that keeps sampling the seed produces different upper bits.

// File: rtl/callguard_pkg.sv
package callguard_pkg;

    typedef enum logic [1:0] {
        TGT_PLAIN  = 2'b00,
        TGT_RETURN = 2'b01,
        TGT_SETUP  = 2'b10,
        TGT_RSVD   = 2'b11
    } tgt_cls_e;

endpackage

// File: rtl/cg_retaddr.sv
module cg_retaddr #(
    parameter int W      = 64,
    parameter int SLOT_LG = 2,
    parameter int BLK_LG = 5
) (
    input  logic [W-1:0] pc_i,
    input  logic         last_i,
    output logic [W-1:0] addr_o
);
    localparam logic [W-1:0] SLOT_BYTES = W'(1) << SLOT_LG;
    localparam logic [W-1:0] BLK_BYTES  = W'(1) << BLK_LG;

    logic [W-1:0] slot_base;
    logic [W-1:0] blk_base;

    always_comb begin
        slot_base = pc_i & ~(SLOT_BYTES - W'(1));
        blk_base  = pc_i & ~(BLK_BYTES - W'(1));
        addr_o    = last_i ? (blk_base + BLK_BYTES) : (slot_base + SLOT_BYTES);
    end
endmodule

// File: rtl/cg_digest.sv
module cg_digest #(
    parameter int             W     = 64,
    parameter int             DIG_W = 12,
    parameter int             ROT   = 23,
    parameter logic [W-1:0]   MULT  = 64'h9E3779B97F4A7C15
) (
    input  logic [W-1:0]     addr_i,
    input  logic [W-1:0]     key_i,
    output logic [DIG_W-1:0] dig_o
);
    localparam int NCH = (W + DIG_W - 1) / DIG_W;
    localparam logic [W-1:0] ADDR_MASK = {W{1'b1}} >> DIG_W;

    logic [W-1:0]         mixed;
    logic [W-1:0]         prod;
    logic [W-1:0]         rot;
    logic [NCH*DIG_W-1:0] padded;
    logic [DIG_W-1:0]     acc;

    always_comb begin
        mixed  = (addr_i & ADDR_MASK) ^ key_i;
        prod   = mixed * MULT;
        rot    = (prod << ROT) | (prod >> (W - ROT));
        padded = '0;
        padded[W-1:0] = rot;
        acc = '0;
        for (int i = 0; i < NCH; i++) begin
            acc = acc ^ padded[i*DIG_W +: DIG_W];
        end
        dig_o = acc;
    end
endmodule

// File: rtl/cg_shadow_stack.sv
module cg_shadow_stack #(
    parameter int W     = 64,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] push_data_i,
    input  logic         pop_i,
    input  logic [W-1:0] cmp_data_i,
    output logic         empty_o,
    output logic         mismatch_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_MAX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [CW-1:0] cnt;
    } stk_t;

    stk_t          stk_d, stk_q;
    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] top_idx;

    always_comb begin
        top_idx    = (stk_q.ptr == '0) ? PTR_MAX : stk_q.ptr - PW'(1);
        empty_o    = (stk_q.cnt == '0);
        mismatch_o = (mem_q[top_idx] != cmp_data_i);
        stk_d      = stk_q;
        if (push_i) begin
            stk_d.ptr = (stk_q.ptr == PTR_MAX) ? '0 : stk_q.ptr + PW'(1);
            if (stk_q.cnt != CNT_MAX) stk_d.cnt = stk_q.cnt + CW'(1);
        end else if (pop_i && !empty_o) begin
            stk_d.ptr = top_idx;
            stk_d.cnt = stk_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    always_ff @(posedge clk) begin
        if (push_i) mem_q[stk_q.ptr] <= push_data_i;
    end

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.cnt <= CNT_MAX);

    // R11
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && stk_q.cnt == CNT_MAX) |=> (stk_q.cnt == CNT_MAX));

    // R12
    excl_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i));
endmodule

// File: rtl/callguard.sv
module callguard
    import callguard_pkg::*;
#(
    parameter int W       = 64,
    parameter int DIG_W   = 12,
    parameter int DEPTH   = 16,
    parameter int SLOT_LG = 2,
    parameter int BLK_LG  = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         guard_en_i,
    input  logic [63:0]  seed_i,
    input  logic         call_i,
    input  logic [63:0]  call_pc_i,
    input  logic         call_last_i,
    input  logic         jump_i,
    input  logic [63:0]  jump_addr_i,
    input  logic [1:0]   tgt_cls_i,
    output logic [63:0]  ret_word_o,
    output logic         violation_o
);
    localparam int PA_W = W - DIG_W;

    typedef struct packed {
        logic [W-1:0] key;
        logic [W-1:0] ret_word;
        logic         viol;
    } gstate_t;

    gstate_t        st_d, st_q;
    tgt_cls_e       cls;
    logic [W-1:0]   ret_addr;
    logic [DIG_W-1:0] dig;
    logic [W-1:0]   word;
    logic           push, pop;
    logic           stk_empty, stk_mismatch;

    cg_retaddr #(.W(W), .SLOT_LG(SLOT_LG), .BLK_LG(BLK_LG)) u_retaddr (
        .pc_i   (call_pc_i),
        .last_i (call_last_i),
        .addr_o (ret_addr)
    );

    cg_digest #(.W(W), .DIG_W(DIG_W)) u_digest (
        .addr_i (ret_addr),
        .key_i  (st_q.key),
        .dig_o  (dig)
    );

    cg_shadow_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_data_i (word),
        .pop_i       (pop),
        .cmp_data_i  (jump_addr_i),
        .empty_o     (stk_empty),
        .mismatch_o  (stk_mismatch)
    );

    always_comb begin
        cls  = tgt_cls_e'(tgt_cls_i);
        word = guard_en_i ? {dig, ret_addr[PA_W-1:0]} : ret_addr;
        push = call_i && guard_en_i && (cls != TGT_SETUP);
        pop  = jump_i && !call_i && guard_en_i && (cls == TGT_RETURN);

        st_d      = st_q;
        st_d.viol = pop && (stk_empty || stk_mismatch);
        if (call_i) st_d.ret_word = word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.key      <= seed_i;
            st_q.ret_word <= '0;
            st_q.viol     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ret_word_o  = st_q.ret_word;
    assign violation_o = st_q.viol;

    // R8
    viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation_o |-> $past(jump_i && !call_i && guard_en_i && tgt_cls_i == 2'b01));

    // R9
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && stk_empty) |=> violation_o);

    // R1
    plain_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !guard_en_i && !call_last_i) |=>
        (ret_word_o == {$past(call_pc_i[63:2]), 2'b00} + 64'd4));

    // R6
    key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(st_q.key));
endmodule

// File: tb/callguard_tb.sv
module callguard_tb;
    localparam logic [63:0] K1 = 64'h5A17_C3E9_0B2D_F481;
    localparam logic [63:0] K2 = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        guard_en_i = 1'b0;
    logic [63:0] seed_i = K1;
    logic        call_i = 1'b0;
    logic [63:0] call_pc_i = '0;
    logic        call_last_i = 1'b0;
    logic        jump_i = 1'b0;
    logic [63:0] jump_addr_i = '0;
    logic [1:0]  tgt_cls_i = 2'b00;
    logic [63:0] ret_word_o;
    logic        violation_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    callguard u_dut (
        .clk(clk), .rst_n(rst_n), .guard_en_i(guard_en_i), .seed_i(seed_i),
        .call_i(call_i), .call_pc_i(call_pc_i), .call_last_i(call_last_i),
        .jump_i(jump_i), .jump_addr_i(jump_addr_i), .tgt_cls_i(tgt_cls_i),
        .ret_word_o(ret_word_o), .violation_o(violation_o)
    );

    function automatic logic [63:0] exp_addr(input logic [63:0] pc, input logic last);
        if (last) return {pc[63:5], 5'b0} + 64'd32;
        return {pc[63:2], 2'b0} + 64'd4;
    endfunction

    function automatic logic [11:0] exp_dig(input logic [63:0] a);
        logic [63:0] m, r;
        m = ({12'h0, a[51:0]} ^ K1) * 64'h9E3779B97F4A7C15;
        r = (m << 23) | (m >> 41);
        return r[11:0] ^ r[23:12] ^ r[35:24] ^ r[47:36] ^ r[59:48] ^ {8'h0, r[63:60]};
    endfunction

    function automatic logic [63:0] exp_word(input logic [63:0] pc, input logic last, input logic en);
        logic [63:0] a;
        a = exp_addr(pc, last);
        if (en) return {exp_dig(a), a[51:0]};
        return a;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_call(input logic [63:0] pc, input logic last, input logic [1:0] cls,
                           input string tag);
        logic [63:0] e;
        e = exp_word(pc, last, guard_en_i);
        @(negedge clk);
        call_i = 1; call_pc_i = pc; call_last_i = last; tgt_cls_i = cls;
        @(negedge clk);
        call_i = 0;
        chk(ret_word_o == e, tag, ret_word_o, e);
    endtask

    task automatic do_jump(input logic [63:0] addr, input logic [1:0] cls, input logic ev,
                           input string tag);
        @(negedge clk);
        jump_i = 1; jump_addr_i = addr; tgt_cls_i = cls;
        @(negedge clk);
        jump_i = 0;
        chk(violation_o == ev, tag, {63'b0, violation_o}, {63'b0, ev});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] bases [3];
        logic [63:0] w [17];
        logic [63:0] a, b;
        bases[0] = 64'h0000_0000_0001_0000;
        bases[1] = 64'hABCD_0000_7777_1240;
        bases[2] = 64'hFFFF_FFFF_FFFF_FFE0;

        repeat (5) @(negedge clk);
        rst_n = 1;
        seed_i = K2;                     // R6: change after reset must be ignored
        @(negedge clk);
        // R13 reset state
        chk(ret_word_o == 64'h0, "R13 ret_word reset", ret_word_o, 64'h0);
        chk(violation_o == 1'b0, "R13 violation reset", {63'b0, violation_o}, 64'h0);

        // R1 R2 R3: disabled sweep over slots, last flag and bases
        for (int bi = 0; bi < 3; bi++)
            for (int s = 0; s < 8; s++)
                for (int l = 0; l < 2; l++)
                    do_call(bases[bi] + 64'(s * 4) + ((s % 2 == 1) ? 64'd2 : 64'd0), l[0], 2'b00,
                            l[0] ? "R2 last-slot return" : "R1 next-slot return");

        guard_en_i = 1;
        // R3 disabled calls pushed nothing; R9/R13 empty pop
        do_jump(64'h0, 2'b01, 1'b1, "R9 R3 empty after disabled calls");
        @(negedge clk);
        chk(violation_o == 1'b0, "R8 violation is one cycle", {63'b0, violation_o}, 64'h0);

        // R4 R5 R6 R8: 16 enabled calls then LIFO returns
        for (int i = 0; i < 16; i++) begin
            a = bases[1] + 64'((i % 8) * 4) + 64'((i / 8) * 256);
            w[i] = exp_word(a, i[0], 1'b1);
            do_call(a, i[0], 2'b00, "R4 R5 digest word");
        end
        for (int i = 15; i >= 0; i--)
            do_jump(w[i], 2'b01, 1'b0, "R8 LIFO matching return");
        do_jump(w[0], 2'b01, 1'b1, "R9 pop after drain");

        // R7 setup call does not push
        do_call(64'h2000, 1'b0, 2'b10, "R7 setup call word");
        do_jump(exp_word(64'h2000, 1'b0, 1'b1), 2'b01, 1'b1, "R7 setup call no push");

        // R10 plain jump does not pop
        a = exp_word(64'h3004, 1'b0, 1'b1);
        do_call(64'h3004, 1'b0, 2'b00, "R10 push");
        do_jump(64'hDEAD, 2'b00, 1'b0, "R10 plain jump no check");
        do_jump(64'hBEEF, 2'b10, 1'b0, "R10 setup-class jump no check");
        do_jump(a, 2'b01, 1'b0, "R10 entry intact");

        // R8 mismatch in any bit
        a = exp_word(64'h4008, 1'b1, 1'b1);
        do_call(64'h4008, 1'b1, 2'b00, "R8 push");
        do_jump(a ^ 64'h8000_0000_0000_0000, 2'b01, 1'b1, "R8 digest bit mismatch");
        @(negedge clk);
        chk(violation_o == 1'b0, "R8 pulse ends", {63'b0, violation_o}, 64'h0);
        do_jump(a, 2'b01, 1'b1, "R8 mismatched entry was consumed");

        // R11 overflow drops oldest
        for (int i = 0; i < 17; i++) begin
            a = 64'h9000 + 64'(i * 32);
            w[i] = exp_word(a, 1'b0, 1'b1);
            do_call(a, 1'b0, 2'b11, "R11 push");
        end
        for (int i = 16; i >= 1; i--)
            do_jump(w[i], 2'b01, 1'b0, "R11 newest sixteen kept");
        do_jump(w[0], 2'b01, 1'b1, "R11 oldest discarded");

        // R12 simultaneous call and jump
        a = exp_word(64'h5000, 1'b0, 1'b1);
        b = exp_word(64'h6000, 1'b0, 1'b1);
        do_call(64'h5000, 1'b0, 2'b00, "R12 first push");
        @(negedge clk);
        call_i = 1; call_pc_i = 64'h6000; call_last_i = 0;
        jump_i = 1; jump_addr_i = 64'h1; tgt_cls_i = 2'b01;
        @(negedge clk);
        call_i = 0; jump_i = 0;
        chk(violation_o == 1'b0, "R12 jump ignored", {63'b0, violation_o}, 64'h0);
        chk(ret_word_o == b, "R12 call taken", ret_word_o, b);
        do_jump(b, 2'b01, 1'b0, "R12 call pushed");

        // R3 disabled return jump leaves stack alone
        guard_en_i = 0;
        do_jump(64'h77, 2'b01, 1'b0, "R3 no check when disabled");
        guard_en_i = 1;
        do_jump(a, 2'b01, 1'b0, "R3 stack untouched when disabled");
        do_jump(a, 2'b01, 1'b1, "R9 final empty");

        finish_run();
    end
endmodule